// File: doc/BRIEF.md
# Branch Condition and Link Resolver

This unit settles every control-transfer instruction that reaches the execute stage. It takes one decoded instruction per cycle: the 4-bit major opcode, the 4-bit sub-operation used by the compare group, a decoded link flag, both register operand values, the instruction's program counter, the carry flag and the 16-bit immediate field. One cycle later it reports three things. The first is whether the transfer is taken. The second is the transfer's destination and the address the fetch stage should use next. The third is an optional write of the return address into the return-address register.

Two families of instructions are handled. In the first, the major opcode alone names the jump or branch: an unconditional jump, a jump through a register, equality tests, zero tests and carry tests. In the second, one major opcode selects a compare group, and the sub-operation picks a less-than or greater-than test, plain or negated, signed or unsigned. Any of these may carry the link form. The link form stores the sequential address whether or not the branch is taken. The PC register, pipeline flushing and instruction decoding sit outside this unit.

Top module: `brl_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, out_valid, out_taken and out_link_we are 0.
- R2: Results appear exactly one clock after an accepted input (in_valid high). In a cycle that follows one with in_valid low, out_valid, out_taken and out_link_we are 0.
- R3: Opcode 4'b1000 (jump) is always taken, and its target is in_pc + 4 + (sign-extended in_imm[15:0] << 2). Opcode 4'b1001 (register jump) is always taken, and its target is in_rega.
- R4: Opcode 4'b1010 is taken when in_rega equals in_regb. Opcode 4'b1011 is taken when they differ. Both use the 16-bit immediate target of R3.
- R5: Opcode 4'b1100 is taken when in_rega is zero. Opcode 4'b1101 is taken when in_rega is non-zero. in_regb has no effect on either.
- R6: Opcode 4'b1110 is taken when in_carry is 1. Opcode 4'b1111 is taken when in_carry is 0.
- R7: Opcode 4'b0111 with in_subop 0..7 is a compare of A against B. The sub-operation codes are: 0 less, 1 less unsigned, 2 not-less, 3 not-less unsigned, 4 greater, 5 greater unsigned, 6 not-greater, 7 not-greater unsigned. Codes without the unsigned flag compare in two's complement. The target is in_pc + 4 + (sign-extended in_imm[7:0] << 2). in_imm[15:8] has no effect.
- R8: Opcode 4'b0111 with in_subop 8..15 is not a control transfer: not taken, no link write, and target and next PC equal in_pc + 4.
- R9: For any control transfer with in_link high, out_link_we is 1, out_link_idx is 4'b0010 and out_link_data is in_pc + 4, taken or not. With in_link low, out_link_we is 0.
- R10: Opcodes 4'b0000 to 4'b0110 are never taken and never write the link register, even with in_link high. Their target and next PC are in_pc + 4.
- R11: out_next_pc equals out_target when taken and in_pc + 4 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_opcode | input | 4 | Major opcode |
| in_subop | input | 4 | Compare-group sub-operation |
| in_link | input | 1 | Link form requested |
| in_rega | input | 32 | Register A value |
| in_regb | input | 32 | Register B value |
| in_pc | input | 32 | Address of the instruction |
| in_carry | input | 1 | Carry flag |
| in_imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Transfer taken |
| out_target | output | 32 | Transfer destination |
| out_next_pc | output | 32 | Next fetch address |
| out_link_we | output | 1 | Return-address write enable |
| out_link_idx | output | 4 | Register index of the write |
| out_link_data | output | 32 | Return address |

## Verification
The bench concentrates on operands whose signed and unsigned orderings disagree, such as all-ones against one. A resolver that mixes up the two flavours takes the wrong arm of every compare there. It uses equal operands, where the not-less and not-greater forms must be taken and the strict forms must not; an off-by-one comparator flips exactly these. It fills the high byte of the immediate with noise on compare-group branches and uses negative offsets. A unit that picks the wide field, or zero-extends, lands at a wrong target. It also issues link requests on untaken branches, on invalid sub-operations and on non-control opcodes, which catch a link write tied to the taken decision or to in_link alone.

// File: rtl/brl_pkg.sv
package brl_pkg;

  // Major opcodes that resolve here
  localparam logic [3:0] OP_CMP  = 4'b0111;
  localparam logic [3:0] OP_J    = 4'b1000;
  localparam logic [3:0] OP_JR   = 4'b1001;
  localparam logic [3:0] OP_BEQ  = 4'b1010;
  localparam logic [3:0] OP_BNE  = 4'b1011;
  localparam logic [3:0] OP_BZ   = 4'b1100;
  localparam logic [3:0] OP_BNZ  = 4'b1101;
  localparam logic [3:0] OP_BC   = 4'b1110;
  localparam logic [3:0] OP_BNC  = 4'b1111;

  // Condition kinds the evaluator knows
  typedef enum logic [2:0] {
    COND_NEVER,
    COND_ALWAYS,
    COND_EQ,
    COND_ZERO,
    COND_CARRY,
    COND_LESS,
    COND_GREATER
  } cond_kind_e;

  typedef struct packed {
    logic       is_ctrl;     // a real control transfer
    logic       reg_target;  // destination taken from register A
    logic       short_imm;   // compare group: narrow offset field
    logic       unsig;       // unsigned ordering
    logic       invert;      // negate the raw condition
    cond_kind_e kind;
  } brl_ctl_t;

endpackage

// File: rtl/brl_decode.sv
module brl_decode
  import brl_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter int SUB_W = 4
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [SUB_W-1:0] subop,
  output brl_ctl_t         ctl
);

  // sub-operation layout: bit0 unsigned, bit1 negate, bit2 greater, top bit reserved
  localparam int SUB_UNS = 0;
  localparam int SUB_NEG = 1;
  localparam int SUB_GT  = 2;
  localparam int SUB_RSV = SUB_W - 1;

  always_comb begin
    ctl            = '0;
    ctl.kind       = COND_NEVER;
    unique case (opcode)
      OP_J:   begin ctl.is_ctrl = 1'b1; ctl.kind = COND_ALWAYS; end
      OP_JR:  begin ctl.is_ctrl = 1'b1; ctl.kind = COND_ALWAYS; ctl.reg_target = 1'b1; end
      OP_BEQ: begin ctl.is_ctrl = 1'b1; ctl.kind = COND_EQ; end
      OP_BNE: begin ctl.is_ctrl = 1'b1; ctl.kind = COND_EQ; ctl.invert = 1'b1; end
      OP_BZ:  begin ctl.is_ctrl = 1'b1; ctl.kind = COND_ZERO; end
      OP_BNZ: begin ctl.is_ctrl = 1'b1; ctl.kind = COND_ZERO; ctl.invert = 1'b1; end
      OP_BC:  begin ctl.is_ctrl = 1'b1; ctl.kind = COND_CARRY; end
      OP_BNC: begin ctl.is_ctrl = 1'b1; ctl.kind = COND_CARRY; ctl.invert = 1'b1; end
      OP_CMP: begin
        ctl.short_imm = 1'b1;
        if (!subop[SUB_RSV]) begin
          ctl.is_ctrl = 1'b1;
          ctl.unsig   = subop[SUB_UNS];
          ctl.invert  = subop[SUB_NEG];
          ctl.kind    = subop[SUB_GT] ? COND_GREATER : COND_LESS;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/brl_cond.sv
module brl_cond
  import brl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  brl_ctl_t        ctl,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            carry,
  output logic            raw_hit,
  output logic            taken
);

  function automatic logic below(input logic [XLEN-1:0] x,
                                 input logic [XLEN-1:0] y,
                                 input logic            uns);
    if (uns) return x < y;
    return $signed(x) < $signed(y);
  endfunction

  always_comb begin
    unique case (ctl.kind)
      COND_ALWAYS:  raw_hit = 1'b1;
      COND_EQ:      raw_hit = (opa == opb);
      COND_ZERO:    raw_hit = (opa == '0);
      COND_CARRY:   raw_hit = carry;
      COND_LESS:    raw_hit = below(opa, opb, ctl.unsig);
      COND_GREATER: raw_hit = below(opb, opa, ctl.unsig);
      default:      raw_hit = 1'b0;
    endcase
  end

  assign taken = ctl.is_ctrl & (raw_hit ^ ctl.invert);

endmodule

// File: rtl/brl_target.sv
module brl_target
  import brl_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int SHORT_W  = 8,
  parameter int WORD_SH  = 2
) (
  input  brl_ctl_t         ctl,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  opa,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  target
);

  localparam logic [XLEN-1:0] STEP = XLEN'(1) << WORD_SH;

  function automatic logic [XLEN-1:0] offset_of(input logic [IMM_W-1:0] f,
                                                input logic            narrow);
    logic [XLEN-1:0] ext;
    if (narrow) ext = XLEN'($signed(f[SHORT_W-1:0]));
    else        ext = XLEN'($signed(f));
    return ext << WORD_SH;
  endfunction

  logic [XLEN-1:0] rel_target;

  assign seq_pc     = pc + STEP;
  assign rel_target = seq_pc + offset_of(imm, ctl.short_imm);

  always_comb begin
    if (!ctl.is_ctrl)        target = seq_pc;
    else if (ctl.reg_target) target = opa;
    else                     target = rel_target;
  end

endmodule

// File: rtl/brl_unit.sv
module brl_unit
  import brl_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              OPC_W    = 4,
  parameter int              SUB_W    = 4,
  parameter int              IMM_W    = 16,
  parameter int              SHORT_W  = 8,
  parameter int              RIDX_W   = 4,
  parameter logic [RIDX_W-1:0] LINK_REG = 4'b0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [SUB_W-1:0]  in_subop,
  input  logic              in_link,
  input  logic [XLEN-1:0]   in_rega,
  input  logic [XLEN-1:0]   in_regb,
  input  logic [XLEN-1:0]   in_pc,
  input  logic              in_carry,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  output logic              out_taken,
  output logic [XLEN-1:0]   out_target,
  output logic [XLEN-1:0]   out_next_pc,
  output logic              out_link_we,
  output logic [RIDX_W-1:0] out_link_idx,
  output logic [XLEN-1:0]   out_link_data
);

  localparam int              WORD_SH = 2;
  localparam logic [XLEN-1:0] STEP    = XLEN'(1) << WORD_SH;

  brl_ctl_t        ctl;
  logic            raw_hit;
  logic            taken_c;
  logic [XLEN-1:0] seq_pc_c;
  logic [XLEN-1:0] target_c;

  // named events for the assertions
  logic            ev_ctrl;
  logic            ev_link_req;
  logic            ev_bad_sub;

  brl_decode #(.OPC_W(OPC_W), .SUB_W(SUB_W)) u_decode (
    .opcode (in_opcode),
    .subop  (in_subop),
    .ctl    (ctl)
  );

  brl_cond #(.XLEN(XLEN)) u_cond (
    .ctl     (ctl),
    .opa     (in_rega),
    .opb     (in_regb),
    .carry   (in_carry),
    .raw_hit (raw_hit),
    .taken   (taken_c)
  );

  brl_target #(.XLEN(XLEN), .IMM_W(IMM_W), .SHORT_W(SHORT_W), .WORD_SH(WORD_SH)) u_target (
    .ctl    (ctl),
    .pc     (in_pc),
    .opa    (in_rega),
    .imm    (in_imm),
    .seq_pc (seq_pc_c),
    .target (target_c)
  );

  assign ev_ctrl     = in_valid & ctl.is_ctrl;
  assign ev_link_req = ev_ctrl & in_link;
  assign ev_bad_sub  = in_valid & (in_opcode == OP_CMP) & in_subop[SUB_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_taken     <= 1'b0;
      out_link_we   <= 1'b0;
      out_target    <= '0;
      out_next_pc   <= '0;
      out_link_data <= '0;
    end else begin
      out_valid   <= in_valid;
      out_taken   <= in_valid & taken_c;
      out_link_we <= ev_link_req;
      if (in_valid) begin
        out_target    <= target_c;
        out_next_pc   <= taken_c ? target_c : seq_pc_c;
        out_link_data <= seq_pc_c;
      end
    end
  end

  assign out_link_idx = LINK_REG;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_taken && !out_link_we));

  // R3
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_opcode == OP_J || in_opcode == OP_JR)) |=> out_taken);

  // R11
  taken_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_taken |-> (out_next_pc == out_target));

  // R11
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_taken) |-> (out_next_pc == $past(in_pc) + STEP));

  // R9
  link_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_link_we |-> (out_valid && out_link_data == $past(in_pc) + STEP));

  // R8
  bad_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_sub |=> (!out_taken && !out_link_we));

  // R10
  non_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_opcode[OPC_W-1] && in_opcode != OP_CMP) |=> (!out_taken && !out_link_we));

endmodule

// File: tb/brl_unit_bench.sv
`timescale 1ns/1ps
module brl_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_opcode = '0;
  logic [3:0]  in_subop = '0;
  logic        in_link = 1'b0;
  logic [31:0] in_rega = '0;
  logic [31:0] in_regb = '0;
  logic [31:0] in_pc = '0;
  logic        in_carry = 1'b0;
  logic [15:0] in_imm = '0;
  logic        out_valid, out_taken, out_link_we;
  logic [31:0] out_target, out_next_pc, out_link_data;
  logic [3:0]  out_link_idx;

  int n_cmp = 0;
  int n_bad = 0;
  logic mon_on = 1'b0;

  typedef struct packed {
    logic        valid;
    logic        taken;
    logic [31:0] target;
    logic [31:0] next_pc;
    logic        link_we;
    logic [31:0] link_data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  brl_unit u_brl_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_subop(in_subop), .in_link(in_link), .in_rega(in_rega), .in_regb(in_regb),
    .in_pc(in_pc), .in_carry(in_carry), .in_imm(in_imm), .out_valid(out_valid),
    .out_taken(out_taken), .out_target(out_target), .out_next_pc(out_next_pc),
    .out_link_we(out_link_we), .out_link_idx(out_link_idx), .out_link_data(out_link_data)
  );

  function automatic void check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endfunction

  // reference model, written from the requirement text
  function automatic exp_t model(logic [3:0] op, logic [3:0] sub, logic lnk,
                                 logic [31:0] a, logic [31:0] b, logic [31:0] pc,
                                 logic cy, logic [15:0] imm);
    exp_t e;
    logic ctrl, hit;
    logic [31:0] seq, wide, narrow, dest;
    seq    = pc + 32'd4;
    wide   = seq + {{14{imm[15]}}, imm, 2'b00};
    narrow = seq + {{22{imm[7]}}, imm[7:0], 2'b00};
    ctrl = 1'b1; hit = 1'b0; dest = wide;
    case (op)
      4'b1000: hit = 1'b1;
      4'b1001: begin hit = 1'b1; dest = a; end
      4'b1010: hit = (a == b);
      4'b1011: hit = (a != b);
      4'b1100: hit = (a == 0);
      4'b1101: hit = (a != 0);
      4'b1110: hit = cy;
      4'b1111: hit = !cy;
      4'b0111: begin
        dest = narrow;
        case (sub)
          4'd0: hit = $signed(a) < $signed(b);
          4'd1: hit = a < b;
          4'd2: hit = $signed(a) >= $signed(b);
          4'd3: hit = a >= b;
          4'd4: hit = $signed(a) > $signed(b);
          4'd5: hit = a > b;
          4'd6: hit = $signed(a) <= $signed(b);
          4'd7: hit = a <= b;
          default: begin ctrl = 1'b0; dest = seq; end
        endcase
      end
      default: begin ctrl = 1'b0; dest = seq; end
    endcase
    e.valid     = 1'b1;
    e.taken     = hit;
    e.target    = dest;
    e.next_pc   = hit ? dest : seq;
    e.link_we   = ctrl & lnk;
    e.link_data = seq;
    return e;
  endfunction

  task automatic issue(logic [3:0] op, logic [3:0] sub, logic lnk, logic [31:0] a,
                       logic [31:0] b, logic [31:0] pc, logic cy, logic [15:0] imm, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_subop = sub; in_link = lnk;
    in_rega = a; in_regb = b; in_pc = pc; in_carry = cy; in_imm = imm;
    exp_q.push_back(model(op, sub, lnk, a, b, pc, cy, imm));
    tag_q.push_back(tag);
  endtask

  task automatic bubble(string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0; in_link = 1'b1; in_opcode = 4'b1000;
    e = '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expectation per cycle, sampled after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check("R2", "out_valid", 32'(out_valid), 32'(e.valid));
        if (!e.valid) begin
          check("R2", "idle out_taken", 32'(out_taken), 32'd0);
          check("R2", "idle out_link_we", 32'(out_link_we), 32'd0);
        end else begin
          check(t, "out_taken", 32'(out_taken), 32'(e.taken));
          check(t, "out_target", out_target, e.target);
          check("R11", "out_next_pc", out_next_pc, e.next_pc);
          check("R9", "out_link_we", 32'(out_link_we), 32'(e.link_we));
          if (e.link_we) begin
            check("R9", "out_link_idx", 32'(out_link_idx), 32'h2);
            check("R9", "out_link_data", out_link_data, e.link_data);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet during reset
    check("R1", "reset out_valid", 32'(out_valid), 32'd0);
    check("R1", "reset out_taken", 32'(out_taken), 32'd0);
    check("R1", "reset out_link_we", 32'(out_link_we), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", "post-reset out_valid", 32'(out_valid), 32'd0);
    check("R1", "post-reset out_link_we", 32'(out_link_we), 32'd0);
    mon_on = 1'b1;

    // R3 jumps, positive and negative offsets, register jump, link forms
    issue(4'b1000, 4'd0, 1'b0, 32'h0, 32'h0, 32'h0000_1000, 1'b0, 16'h0010, "R3");
    issue(4'b1000, 4'd0, 1'b1, 32'h0, 32'h0, 32'h0000_1000, 1'b0, 16'hFFF0, "R3");
    issue(4'b1001, 4'd0, 1'b1, 32'hDEAD_BEE0, 32'h0, 32'h0000_2000, 1'b0, 16'h1234, "R3");
    bubble("R2");
    // R4 equality tests
    issue(4'b1010, 4'd0, 1'b0, 32'h55, 32'h55, 32'h100, 1'b0, 16'h0008, "R4");
    issue(4'b1010, 4'd0, 1'b1, 32'h55, 32'h56, 32'h100, 1'b0, 16'h0008, "R4");
    issue(4'b1011, 4'd0, 1'b0, 32'h55, 32'h56, 32'h200, 1'b0, 16'h8000, "R4");
    issue(4'b1011, 4'd0, 1'b0, 32'h55, 32'h55, 32'h200, 1'b0, 16'h8000, "R4");
    // R5 zero tests, regb noise
    issue(4'b1100, 4'd0, 1'b0, 32'h0, 32'hFFFF_FFFF, 32'h300, 1'b0, 16'h0003, "R5");
    issue(4'b1100, 4'd0, 1'b0, 32'h1, 32'h0, 32'h300, 1'b0, 16'h0003, "R5");
    issue(4'b1101, 4'd0, 1'b1, 32'h8000_0000, 32'h0, 32'h300, 1'b0, 16'h0003, "R5");
    issue(4'b1101, 4'd0, 1'b0, 32'h0, 32'h7, 32'h300, 1'b0, 16'h0003, "R5");
    // R6 carry tests
    issue(4'b1110, 4'd0, 1'b0, 32'h0, 32'h0, 32'h400, 1'b1, 16'h0020, "R6");
    issue(4'b1110, 4'd0, 1'b0, 32'h0, 32'h0, 32'h400, 1'b0, 16'h0020, "R6");
    issue(4'b1111, 4'd0, 1'b0, 32'h0, 32'h0, 32'h400, 1'b0, 16'h0020, "R6");
    issue(4'b1111, 4'd0, 1'b1, 32'h0, 32'h0, 32'h400, 1'b1, 16'h0020, "R6");
    bubble("R2");
    // R7 compares: signed/unsigned disagreement, equal operands, noisy high imm byte
    for (int s = 0; s < 8; s++) begin
      issue(4'b0111, 4'(s), 1'b0, 32'hFFFF_FFFF, 32'h1, 32'h800, 1'b0, 16'hA5FE, "R7");
      issue(4'b0111, 4'(s), 1'b0, 32'h1234, 32'h1234, 32'h800, 1'b0, 16'h5A04, "R7");
      issue(4'b0111, 4'(s), 1'b1, 32'h7FFF_FFFF, 32'h8000_0000, 32'h900, 1'b0, 16'hFF80, "R7");
    end
    // R8 reserved sub-operations with link request
    for (int s = 8; s < 16; s++)
      issue(4'b0111, 4'(s), 1'b1, 32'h0, 32'h5, 32'hA00, 1'b1, 16'h0011, "R8");
    // R10 non-control opcodes with link request
    for (int o = 0; o < 7; o++)
      issue(4'(o), 4'd0, 1'b1, 32'h0, 32'h0, 32'hB00, 1'b1, 16'h0004, "R10");
    bubble("R2");
    // R9 link on an untaken conditional
    issue(4'b1010, 4'd0, 1'b1, 32'h1, 32'h2, 32'hC00, 1'b0, 16'h0040, "R9");
    // R11 mixed traffic
    for (int k = 0; k < 400; k++) begin
      if (k % 13 == 0) bubble("R2");
      else issue(4'($urandom), 4'($urandom), 1'($urandom), ($urandom % 3 == 0) ? 32'h0 : $urandom,
                 ($urandom % 4 == 0) ? 32'h0 : $urandom, $urandom & 32'hFFFF_FFFC,
                 1'($urandom), 16'($urandom), "R11");
    end
    bubble("R2");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule